// File: doc/BRIEF.md
# Two-Group ADC Scan Sequencer

The block sequences an external analog-to-digital converter over four inputs. The inputs form two groups: group 0 holds channels 0 and 1, and group 1 holds channels 2 and 3. Each scan converts both channels of one group, the lower-numbered channel first. A scan begins in one of two ways. A software start pulse names the group through a channel-select field. Otherwise, a pulse on one of sixteen hardware trigger lines starts the group whose own 4-bit trigger select names that line.

For each conversion the sequencer sends a one-cycle start pulse and a channel number to the converter. It then waits for a done pulse, which carries the result, and stores the result in that channel's 10-bit data register. Only one group can scan at a time. A request that arrives while a scan is in progress is discarded and is never held for later. The group that is not scanning keeps its data registers unchanged.

In single mode the sequencer sets an end-of-scan flag after the second result and goes idle. In continuous mode it restarts the same group until software halts it. The flag drives an interrupt when the interrupt enable is set, and software clears the flag by writing 1.

Top module: `adc_pair_scan`

## Requirements
- R1: After reset, all four data outputs are 0, `eos_flag` is 0, `irq` is 0 and `conv_start` is 0.
- R2: A `sw_start` pulse while idle starts group 0 when `ch_sel[1]` is 0 and group 1 when `ch_sel[1]` is 1. Bits 0 and 2 of `ch_sel` have no effect.
- R3: While idle, a pulse on `trig_in[k]` starts group g when `trig_sel_g` equals k and k is not 0. A select value of 0 disables hardware starts for that group, and pulses on lines that no group selects start nothing.
- R4: A scan of group g issues two conversions. The first has `conv_ch` = 2g and the second has `conv_ch` = 2g+1. Each `conv_start` is high for exactly one cycle, and the first one follows the accepted request by one cycle.
- R5: When `conv_done` is high, `conv_data` is written to the data output of the channel being converted. That output shows the new value one cycle later.
- R6: Any start request (software, or a trigger for either group) that arrives while a scan is in progress is dropped. It is never serviced later.
- R7: When group 0 and group 1 requests arrive in the same idle cycle, only group 0 is scanned.
- R8: In single mode (`cont_mode` = 0), `eos_flag` is set in the cycle after the second result is accepted, and the sequencer returns to idle.
- R9: In continuous mode (`cont_mode` = 1), the same group restarts right after each scan without any new request. A `sw_halt` pulse lets the current scan finish and then stops the sequencer.
- R10: While one group is scanning, the data outputs of the other group keep their values.
- R11: `irq` equals `eos_flag` AND `irq_en`.
- R12: A `flag_clr` pulse clears `eos_flag`. If the flag is being set in the same cycle, setting takes priority and the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_start | input | 1 | Software start pulse |
| sw_halt | input | 1 | Pulse that stops continuous scanning |
| ch_sel | input | 3 | Channel select; bit 1 picks the group on software start |
| cont_mode | input | 1 | 1 = continuous scan, 0 = single scan |
| trig_sel0 | input | 4 | Trigger line for group 0 (0 = none) |
| trig_sel1 | input | 4 | Trigger line for group 1 (0 = none) |
| trig_in | input | 16 | Single-cycle hardware trigger pulses |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-1 clear of the end-of-scan flag |
| conv_start | output | 1 | Converter start pulse |
| conv_ch | output | 2 | Channel to be converted |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| data_ch0 | output | 10 | Channel 0 result |
| data_ch1 | output | 10 | Channel 1 result |
| data_ch2 | output | 10 | Channel 2 result |
| data_ch3 | output | 10 | Channel 3 result |
| eos_flag | output | 1 | End-of-scan flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the end-of-scan flag being set by the second result of a scan, and a software clear of that flag. The converter model in the bench raises `flag_clr` on the exact cycle it returns that second result, and it does so while the flag is still set from an earlier scan. The bench judges the result by the flag reading 1 afterwards. The bench also drives both groups' triggers in one cycle, and checks that group 0 alone is scanned by counting the conversions and watching that the group 1 registers do not change.

// File: rtl/adc_pair_scan.sv
module adc_pair_scan #(
  parameter int RES_W  = 10,
  parameter int TRIG_N = 16,
  localparam int SEL_W = $clog2(TRIG_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             sw_halt,
  input  logic [2:0]       ch_sel,
  input  logic             cont_mode,
  input  logic [SEL_W-1:0] trig_sel0,
  input  logic [SEL_W-1:0] trig_sel1,
  input  logic [TRIG_N-1:0] trig_in,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             conv_start,
  output logic [1:0]       conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] data_ch0,
  output logic [RES_W-1:0] data_ch1,
  output logic [RES_W-1:0] data_ch2,
  output logic [RES_W-1:0] data_ch3,
  output logic             eos_flag,
  output logic             irq
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t st;
  logic grp, idx, run_bit;
  logic [RES_W-1:0] dreg [4];

  wire hit0 = (trig_sel0 != '0) && trig_in[trig_sel0];
  wire hit1 = (trig_sel1 != '0) && trig_in[trig_sel1];
  wire req0 = hit0 | (sw_start & ~ch_sel[1]);
  wire req1 = hit1 | (sw_start &  ch_sel[1]);
  wire accept = (st == S_IDLE) && (req0 || req1);
  wire last_done = (st == S_WAIT) && conv_done && idx;
  wire keep = cont_mode & run_bit & ~sw_halt;

  assign conv_start = (st == S_ISSUE);
  assign conv_ch    = {grp, idx};
  assign data_ch0   = dreg[0];
  assign data_ch1   = dreg[1];
  assign data_ch2   = dreg[2];
  assign data_ch3   = dreg[3];
  assign irq        = eos_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      grp <= 1'b0;
      idx <= 1'b0;
      for (int i = 0; i < 4; i++) dreg[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          grp <= ~req0;
          idx <= 1'b0;
          st  <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (conv_done) begin
          dreg[{grp, idx}] <= conv_data;
          if (!idx) begin
            idx <= 1'b1;
            st  <= S_ISSUE;
          end else begin
            idx <= 1'b0;
            st  <= keep ? S_ISSUE : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_bit <= 1'b0;
    else if (accept)                    run_bit <= 1'b1;
    else if (sw_halt || (last_done && !keep)) run_bit <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         eos_flag <= 1'b0;
    else if (last_done) eos_flag <= 1'b1;
    else if (flag_clr)  eos_flag <= 1'b0;
  end

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_low_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (conv_start && !conv_ch[0]));

  assert_hold_g1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !grp) |=> ($stable(data_ch2) && $stable(data_ch3)));

  assert_hold_g0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && grp) |=> ($stable(data_ch0) && $stable(data_ch1)));

  assert_set_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_flag) |-> $past(conv_done));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !last_done) |=> !eos_flag);

endmodule

// File: tb/test_adc_pair_scan.sv
module test_adc_pair_scan;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;

  logic clk = 0, rst_n = 0;
  logic sw_start = 0, sw_halt = 0, cont_mode = 0, irq_en = 0, flag_clr = 0;
  logic [2:0] ch_sel = 0;
  logic [3:0] trig_sel0 = 0, trig_sel1 = 0;
  logic [15:0] trig_in = 0;
  logic conv_start, conv_done = 0;
  logic [1:0] conv_ch;
  logic [9:0] conv_data = 0;
  logic [9:0] d0, d1, d2, d3;
  logic eos_flag, irq;

  adc_pair_scan i_adc_pair_scan (
    .clk, .rst_n, .sw_start, .sw_halt, .ch_sel, .cont_mode, .trig_sel0, .trig_sel1,
    .trig_in, .irq_en, .flag_clr, .conv_start, .conv_ch, .conv_done, .conv_data,
    .data_ch0(d0), .data_ch1(d1), .data_ch2(d2), .data_ch3(d3), .eos_flag, .irq);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int nconv = 0, cd = 0;
  logic pend = 0, clr_now = 0, clr_arm = 0;
  logic [1:0] pch = 0, prev_ch = 0, cur_ch = 0;
  logic [9:0] pval = 0;
  logic [9:0] exp_d [4] = '{default: '0};

  // converter model: fixed latency, result derived from channel and sequence number
  always @(negedge clk) begin
    conv_done = 0;
    flag_clr = clr_now;
    clr_now = 0;
    if (pend) begin
      if (cd == 0) begin
        conv_done = 1; conv_data = pval; exp_d[pch] = pval; pend = 0;
        if (clr_arm && pch[0]) flag_clr = 1;
      end else cd--;
    end
    if (conv_start) begin
      pend = 1; cd = LAT; pch = conv_ch;
      prev_ch = cur_ch; cur_ch = conv_ch;
      nconv++;
      pval = 10'((conv_ch * 97 + nconv * 13) & 10'h3FF);
    end
  end

  function logic [9:0] dv(int c);
    case (c) 0: return d0; 1: return d1; 2: return d2; default: return d3; endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_trig(int b);
    @(negedge clk); trig_in = 16'(1 << b); @(negedge clk); trig_in = 0;
  endtask

  task automatic pulse_sw(int sel);
    @(negedge clk); ch_sel = 3'(sel); sw_start = 1; @(negedge clk); sw_start = 0;
  endtask

  task automatic clear_flag; clr_now = 1; tick(2); endtask

  // wait for scan of group g to complete, then check results
  task automatic expect_scan(int g, int base, string tag);
    logic [9:0] o0, o1;
    o0 = dv(2 - 2*g); o1 = dv(3 - 2*g);
    for (int i = 0; i < 60 && !(nconv == base + 2 && eos_flag); i++) tick(1);
    tick(3);
    chk(nconv == base + 2, {tag, " R8 conv count"}, nconv - base, 2);
    chk(eos_flag == 1, {tag, " R8 eos"}, eos_flag, 1);
    chk(prev_ch == 2'(2*g) && cur_ch == 2'(2*g+1), {tag, " R4 order"}, {prev_ch, cur_ch}, (2*g)*4 + 2*g + 1);
    chk(dv(2*g) == exp_d[2*g] && dv(2*g+1) == exp_d[2*g+1], {tag, " R5 data"}, dv(2*g+1), exp_d[2*g+1]);
    chk(dv(2 - 2*g) == o0 && dv(3 - 2*g) == o1, {tag, " R10 other group held"}, dv(3 - 2*g), o1);
    clear_flag();
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int base;
    tick(3); rst_n = 1; tick(1);
    chk(d0 == 0 && d1 == 0 && d2 == 0 && d3 == 0, "R1 data zero", d0 | d1 | d2 | d3, 0);
    chk(eos_flag == 0 && irq == 0 && conv_start == 0, "R1 flags", {eos_flag, irq, conv_start}, 0);

    // software start: every ch_sel value, group taken from bit 1
    for (int s = 0; s < 8; s++) begin
      base = nconv; pulse_sw(s); expect_scan((s >> 1) & 1, base, "R2 sw start");
    end

    // interrupt gating and clear
    base = nconv; pulse_sw(0); expect_scan(0, base, "R11 setup");
    pulse_sw(0); for (int i = 0; i < 40 && !eos_flag; i++) tick(1); tick(1);
    chk(irq == 0, "R11 irq masked", irq, 0);
    irq_en = 1; tick(1);
    chk(irq == 1, "R11 irq enabled", irq, 1);
    clear_flag();
    chk(eos_flag == 0 && irq == 0, "R12 clear", eos_flag, 0);

    // hardware trigger sweep over every select value for both groups
    for (int g = 0; g < 2; g++) begin
      for (int s = 1; s < 16; s++) begin
        trig_sel0 = (g == 0) ? 4'(s) : 4'd0;
        trig_sel1 = (g == 1) ? 4'(s) : 4'd0;
        base = nconv; pulse_trig(s); expect_scan(g, base, "R3 trigger");
        base = nconv; pulse_trig((s % 15) + 1 == s ? 0 : (s % 15) + 1); tick(12);
        chk(nconv == base, "R3 unselected line ignored", nconv - base, 0);
      end
    end

    // select 0 means no hardware start
    trig_sel0 = 0; trig_sel1 = 0; base = nconv;
    @(negedge clk); trig_in = 16'hFFFF; @(negedge clk); trig_in = 0; tick(12);
    chk(nconv == base, "R3 select zero", nconv - base, 0);

    // requests during a scan are dropped, both directions
    trig_sel0 = 4; trig_sel1 = 9;
    base = nconv; pulse_sw(0); pulse_trig(9); pulse_sw(2);
    expect_scan(0, base, "R6 g1 during g0");
    tick(10); chk(nconv == base + 2, "R6 not queued g1", nconv - base, 2);
    base = nconv; pulse_sw(2); pulse_trig(4); pulse_sw(0);
    expect_scan(1, base, "R6 g0 during g1");
    tick(10); chk(nconv == base + 2, "R6 not queued g0", nconv - base, 2);

    // simultaneous requests: group 0 wins
    base = nconv; @(negedge clk); trig_in = 16'h0210; @(negedge clk); trig_in = 0;
    expect_scan(0, base, "R7 both triggers");
    tick(10); chk(nconv == base + 2, "R7 loser dropped", nconv - base, 2);
    base = nconv; @(negedge clk); trig_in = 16'h0010; ch_sel = 2; sw_start = 1;
    @(negedge clk); trig_in = 0; sw_start = 0;
    expect_scan(0, base, "R7 sw g1 vs trig g0");

    // continuous mode until halt
    cont_mode = 1;
    begin
      logic [9:0] h2, h3;
      h2 = d2; h3 = d3; base = nconv;
      pulse_sw(0);
      for (int i = 0; i < 200 && nconv < base + 6; i++) tick(1);
      chk(nconv >= base + 6, "R9 restarts without request", nconv - base, 6);
      @(negedge clk); sw_halt = 1; @(negedge clk); sw_halt = 0;
      tick(30);
      chk(((nconv - base) % 2) == 0, "R9 halt finishes scan", (nconv - base) % 2, 0);
      base = nconv; tick(20);
      chk(nconv == base, "R9 stopped after halt", nconv - base, 0);
      chk(d2 == h2 && d3 == h3, "R10 group1 held in continuous", d3, h3);
      chk(d0 == exp_d[0] && d1 == exp_d[1], "R5 continuous data", d1, exp_d[1]);
    end
    cont_mode = 0;

    // flag set and clear in the same cycle: set wins
    base = nconv; pulse_sw(2); expect_scan(1, base, "R12 prep");
    pulse_sw(2); for (int i = 0; i < 40 && !eos_flag; i++) tick(1);
    chk(eos_flag == 1, "R12 flag set before race", eos_flag, 1);
    clr_arm = 1; base = nconv; pulse_sw(2);
    for (int i = 0; i < 40 && nconv < base + 2; i++) tick(1);
    tick(LAT + 4); clr_arm = 0;
    chk(eos_flag == 1, "R12 set beats clear", eos_flag, 1);
    clear_flag();
    chk(eos_flag == 0, "R12 plain clear", eos_flag, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule